// File: doc/BRIEF.md
# Film Cadence Field-ID Pulse Generator

This block produces a periodic marker that downstream equipment uses to recover the film-to-video cadence of a stream. It watches the horizontal-sync leading-edge strobe, the current line number and the field indication of a video timing generator, all on the pixel clock. Once every 5 frames (for the 30 and 29.97 frame-per-second rates) or once every 10 frames (for the 60 and 59.94 rates), it raises a marker that starts at the sync leading edge of line 1 of field 1. For any other frame rate it stays at its idle level.

The marker has two width modes. The short mode holds it for exactly one line. The span mode holds it from line 1 of the first field until line 1 of the second field. A host register supplies the mode bit and a polarity bit. A sequence counter counts frames modulo the cadence length. The counter restarts whenever the frame-rate class changes, so a new cadence always begins with a marker on the next frame.

Top module: `cadence_marker_gen`

## Requirements
- R1: `rate_sel` codes 0 (29.97 fps) and 1 (30 fps) select the 5-frame class, and codes 2 (59.94 fps) and 3 (60 fps) select the 10-frame class. Codes 4 to 7 are unsupported, and with them `marker_o` stays at the inactive level.
- R2: In the 5-frame class the marker starts on every 5th frame start. A frame start is an `hs_lead` strobe with `line_num` = 1 and `field_id` = 0.
- R3: In the 10-frame class the marker starts on every 10th frame start.
- R4: After reset, the first frame start in a supported class starts a marker.
- R5: With `mode_span` = 0 the marker goes active on the cycle after the frame-start strobe. It returns inactive on the cycle after the next `hs_lead` strobe, whatever that line is.
- R6: With `mode_span` = 1 the marker goes active on the cycle after the frame-start strobe. It returns inactive on the cycle after the strobe with `line_num` = 1 and `field_id` = 1. Other strobes do not end it.
- R7: With `pol_low` = 0 the active level is 1. With `pol_low` = 1 the output is inverted. Under reset the output sits at the inactive level.
- R8: A change of `mode_span` while a marker is active does not alter that marker. The new mode applies from the next marker.
- R9: A change of the frame-rate class clears the sequence, so the next frame start starts a marker.
- R10: The marker level changes only on the cycle after an `hs_lead` strobe (or after a change of `pol_low` or `rate_sel`). Within a line it holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_lead | input | 1 | One-cycle strobe at the horizontal-sync leading edge |
| line_num | input | LINE_W | Line number within the current field, first line is 1 |
| field_id | input | 1 | 0 = first field, 1 = second field |
| rate_sel | input | RATE_W | Frame-rate code, see R1 |
| mode_span | input | 1 | 0 = one-line marker, 1 = first-to-second-field marker |
| pol_low | input | 1 | 1 inverts the output (active low) |
| marker_o | output | 1 | Registered cadence marker |

## Verification
Every marker transition is due on the first clock edge after the `hs_lead` strobe that causes it, because a single output register follows the decision logic. The bench drives each strobe at a falling edge and releases it one falling edge later. At that moment it samples the marker, which is the first value after the transition is due. It samples again three cycles later in the same line to confirm the level holds. After a change of `rate_sel` the bench waits two cycles before the next strobe. This lets the class-change restart, which is due one edge later, take effect before any frame start.

// File: rtl/cadence_pkg.sv
package cadence_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_LONG  = 2'd2
  } cad_class_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LINE = 2'd1,
    PS_SPAN = 2'd2
  } pulse_st_e;

  localparam int RATE_CODE_2997 = 0;
  localparam int RATE_CODE_30   = 1;
  localparam int RATE_CODE_5994 = 2;
  localparam int RATE_CODE_60   = 3;
endpackage

// File: rtl/cadence_rate_dec.sv
module cadence_rate_dec
  import cadence_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic [RATE_W-1:0] rate_sel,
  output cad_class_e        cls
);
  // R1: the two low codes map to the 5-frame class, the next two to the 10-frame class
  always_comb begin
    if (rate_sel == RATE_W'(RATE_CODE_2997) || rate_sel == RATE_W'(RATE_CODE_30))
      cls = CLS_SHORT;
    else if (rate_sel == RATE_W'(RATE_CODE_5994) || rate_sel == RATE_W'(RATE_CODE_60))
      cls = CLS_LONG;
    else
      cls = CLS_NONE;
  end
endmodule

// File: rtl/cadence_seq_cnt.sv
module cadence_seq_cnt
  import cadence_pkg::*;
#(
  parameter int SHORT_LEN = 5,
  parameter int LONG_LEN  = 10,
  parameter int CNT_W     = $clog2(LONG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  cad_class_e       cls,
  input  logic             ev_frame,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

  cad_class_e       cls_q;
  logic             restart;
  logic [CNT_W-1:0] last;

  assign restart = (cls != cls_q);                  // R9
  assign last    = (cls == CLS_LONG) ? LONG_LAST : SHORT_LAST;
  assign fire    = ev_frame && !restart && (cls != CLS_NONE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q <= CLS_NONE;
      cnt   <= '0;
    end else begin
      cls_q <= cls;
      if (restart || cls == CLS_NONE)
        cnt <= '0;
      else if (ev_frame)
        cnt <= (cnt >= last) ? '0 : cnt + 1'b1;     // R2 / R3 modulo wrap
    end
  end
endmodule

// File: rtl/cadence_pulse_fsm.sv
module cadence_pulse_fsm
  import cadence_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sup,
  input  logic      fire,
  input  logic      mode_span,
  input  logic      hs_lead,
  input  logic      ev_f2,
  output pulse_st_e st,
  output logic      act_nxt
);
  pulse_st_e st_nxt;

  // The state records the mode a marker was started in, so a later mode
  // change cannot reshape it (R8).
  always_comb begin
    st_nxt = st;
    if (!sup) begin
      st_nxt = PS_IDLE;
    end else begin
      unique case (st)
        PS_IDLE: if (fire) st_nxt = mode_span ? PS_SPAN : PS_LINE;
        PS_LINE: begin
          if (fire)         st_nxt = mode_span ? PS_SPAN : PS_LINE;
          else if (hs_lead) st_nxt = PS_IDLE;       // R5
        end
        PS_SPAN: begin
          if (fire)       st_nxt = mode_span ? PS_SPAN : PS_LINE;
          else if (ev_f2) st_nxt = PS_IDLE;         // R6
        end
        default: st_nxt = PS_IDLE;
      endcase
    end
  end

  assign act_nxt = (st_nxt != PS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) st <= PS_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/cadence_out_reg.sv
module cadence_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic act_nxt,
  input  logic pol_low,
  output logic marker_o
);
  // R7: the polarity is applied at the output register
  always_ff @(posedge clk) begin
    if (rst) marker_o <= pol_low;
    else     marker_o <= act_nxt ^ pol_low;
  end
endmodule

// File: rtl/cadence_marker_gen.sv
module cadence_marker_gen
  import cadence_pkg::*;
#(
  parameter int LINE_W     = 11,
  parameter int RATE_W     = 3,
  parameter int FIRST_LINE = 1,
  parameter int SHORT_LEN  = 5,
  parameter int LONG_LEN   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_lead,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              mode_span,
  input  logic              pol_low,
  output logic              marker_o
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);

  cad_class_e       cls;
  logic             sup;
  logic             ev_line1;
  logic             ev_frame;
  logic             ev_f2;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  pulse_st_e        st;
  logic             act_nxt;

  assign sup      = (cls != CLS_NONE);
  assign ev_line1 = hs_lead && (line_num == LINE_W'(FIRST_LINE));
  assign ev_frame = ev_line1 && !field_id;
  assign ev_f2    = ev_line1 && field_id;

  cadence_rate_dec #(.RATE_W(RATE_W)) u_dec (
    .rate_sel (rate_sel),
    .cls      (cls)
  );

  cadence_seq_cnt #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cls      (cls),
    .ev_frame (ev_frame),
    .fire     (fire),
    .cnt      (cnt)
  );

  cadence_pulse_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sup       (sup),
    .fire      (fire),
    .mode_span (mode_span),
    .hs_lead   (hs_lead),
    .ev_f2     (ev_f2),
    .st        (st),
    .act_nxt   (act_nxt)
  );

  cadence_out_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .act_nxt  (act_nxt),
    .pol_low  (pol_low),
    .marker_o (marker_o)
  );
endmodule

// File: rtl/cadence_marker_chk.sv
module cadence_marker_chk
  import cadence_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LONG_LEN = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             hs_lead,
  input logic             pol_low,
  input logic             sup,
  input logic             fire,
  input logic             ev_f2,
  input logic [CNT_W-1:0] cnt,
  input pulse_st_e        st,
  input logic             marker_o
);
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_LEN - 1);

  p_idle_unsup_r1: assert property (@(posedge clk) disable iff (rst)
    !sup |=> (marker_o == $past(pol_low)));

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LONG_LAST);

  p_fire_starts_r4: assert property (@(posedge clk) disable iff (rst)
    fire |=> (st != PS_IDLE));

  p_line_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (st == PS_LINE && hs_lead && !fire) |=> (st == PS_IDLE));

  p_span_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (st == PS_SPAN && sup && !ev_f2 && !fire) |=> (st == PS_SPAN));

  p_level_steady_r10: assert property (@(posedge clk) disable iff (rst)
    (!hs_lead && sup && $stable(pol_low)) |=> $stable(marker_o));
endmodule

bind cadence_marker_gen cadence_marker_chk #(
  .CNT_W    (CNT_W),
  .LONG_LEN (LONG_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hs_lead  (hs_lead),
  .pol_low  (pol_low),
  .sup      (sup),
  .fire     (fire),
  .ev_f2    (ev_f2),
  .cnt      (cnt),
  .st       (st),
  .marker_o (marker_o)
);

// File: tb/cadence_marker_gen_tb.sv
module cadence_marker_gen_tb;
  localparam int LINE_W = 11;
  localparam int RATE_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hs_lead = 1'b0;
  logic [LINE_W-1:0] line_num = '0;
  logic              field_id = 1'b0;
  logic [RATE_W-1:0] rate_sel = 3'd1;
  logic              mode_span = 1'b0;
  logic              pol_low = 1'b0;
  logic              marker_o;

  int n_vec = 0;
  int n_bad = 0;
  logic obs [0:1][1:3];

  always #4 clk = ~clk;   // 125 MHz

  cadence_marker_gen u_dut (
    .clk (clk), .rst (rst), .hs_lead (hs_lead), .line_num (line_num),
    .field_id (field_id), .rate_sel (rate_sel), .mode_span (mode_span),
    .pol_low (pol_low), .marker_o (marker_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: marker_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One line: strobe, sample the cycle after, sample again mid-line (R10)
  task automatic do_line(input int ln, input logic fld);
    logic v0;
    @(negedge clk);
    line_num = LINE_W'(ln); field_id = fld; hs_lead = 1'b1;
    @(negedge clk);
    hs_lead = 1'b0;
    v0 = marker_o;
    obs[fld][ln] = v0;
    repeat (3) @(negedge clk);
    chk(marker_o, v0, "R10 steady within line");
  endtask

  task automatic do_frame();
    for (int f = 0; f < 2; f++)
      for (int l = 1; l <= 3; l++)
        do_line(l, f[0]);
  endtask

  task automatic set_rate(input logic [RATE_W-1:0] r);
    @(negedge clk); rate_sel = r;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(marker_o, 1'b0, "R7 reset inactive");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(marker_o, 1'b0, "R7 idle after reset");
  endtask

  task automatic t_short_cadence();
    mode_span = 1'b0;
    for (int k = 0; k < 11; k++) begin
      do_frame();
      chk(obs[0][1], (k % 5 == 0), k == 0 ? "R4 first frame fires" : "R2 5-frame cadence");
      chk(obs[0][2], 1'b0, "R5 one line only");
      chk(obs[1][1], 1'b0, "R2 field 2 no marker");
    end
  endtask

  task automatic t_long_cadence();
    set_rate(3'd3);
    for (int k = 0; k < 21; k++) begin
      do_frame();
      chk(obs[0][1], (k % 10 == 0), k == 0 ? "R9 class change restarts" : "R3 10-frame cadence");
      chk(obs[0][2], 1'b0, "R5 one line only");
    end
  endtask

  task automatic t_span();
    set_rate(3'd0);
    mode_span = 1'b1;
    for (int k = 0; k < 6; k++) begin
      do_frame();
      chk(obs[0][1], (k % 5 == 0), "R6 span start");
      chk(obs[0][3], (k % 5 == 0), "R6 held through field 1");
      chk(obs[1][1], 1'b0, "R6 ends at field 2 line 1");
    end
    mode_span = 1'b0;
  endtask

  task automatic t_polarity();
    set_rate(3'd2);
    @(negedge clk); pol_low = 1'b1;
    @(negedge clk);
    chk(marker_o, 1'b1, "R7 inverted idle level");
    for (int k = 0; k < 2; k++) begin
      do_frame();
      chk(obs[0][1], (k != 0), "R7 active low marker");
      chk(obs[0][2], 1'b1, "R7 inverted after line");
    end
    @(negedge clk); pol_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_unsupported();
    set_rate(3'd5);
    for (int k = 0; k < 12; k++) begin
      do_frame();
      chk(obs[0][1], 1'b0, "R1 unsupported rate idle");
    end
    set_rate(3'd6);
    mode_span = 1'b1;
    do_frame();
    chk(obs[0][1], 1'b0, "R1 unsupported rate idle span");
    mode_span = 1'b0;
  endtask

  task automatic t_mode_change();
    set_rate(3'd1);
    mode_span = 1'b1;
    do_line(1, 1'b0);
    chk(obs[0][1], 1'b1, "R8 span marker started");
    mode_span = 1'b0;
    do_line(2, 1'b0);
    chk(obs[0][2], 1'b1, "R8 old mode kept");
    do_line(3, 1'b0);
    do_line(1, 1'b1);
    chk(obs[1][1], 1'b0, "R8 old mode end point");
    do_line(2, 1'b1);
    do_line(3, 1'b1);
    for (int k = 1; k < 6; k++) do_frame();
    chk(obs[0][1], 1'b1, "R8 new mode at next marker");
    chk(obs[0][2], 1'b0, "R8 new mode one line");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_short_cadence();
        t_long_cadence();
        t_span();
        t_polarity();
        t_unsupported();
        t_mode_change();
      end
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule